// File: doc/BRIEF.md
# Trigger-Selected Sample Capture Queue

This block takes a 16-bit filtered sample word and pushes it into an eight-word queue whenever a chosen trigger fires. A 3-bit select input names that trigger. It can be one of three timer event pulses, the filter's new-data strobe, or a software load bit that clears itself. Three select codes are reserved and never cause a load. Samples leave the queue through a valid/ready output stream. Plain status pins report empty, full, the current fill level and a sticky overflow flag.

The source filter produces a new sample at five times the burst frequency. The timers that produce the event pulses are outside the block. Loads happen at the clock edge where the selected trigger is high, and the sample present at that edge is stored.

Back-pressure works as follows. `out_valid` is high whenever the queue holds data, and `out_data` is the oldest word. A word is removed at each edge where `out_valid` and `out_ready` are both high. Holding `out_ready` low keeps the word in place, and the queue keeps filling until it is full. The load side cannot be stalled. A load that finds no room is dropped and recorded in the overflow flag.

Top module: `trig_sample_fifo`

## Requirements
- R1: The queue holds up to 8 words. `level` gives the number stored. `empty` is high at level 0 and `full` is high at level 8.
- R2: With `src_sel` at 3'b000, 3'b001 or 3'b010, a load happens at each edge where `tmr_evt[0]`, `tmr_evt[1]` or `tmr_evt[2]` respectively is high. The load stores `smp_data` as sampled at that edge.
- R3: Codes 3'b011, 3'b100 and 3'b101 never cause a load. A software load write made under these codes is ignored.
- R4: With code 3'b110, a load happens at each edge where `smp_rdy` is high.
- R5: With code 3'b111, a `reg_wr` with `reg_wdata[0]`=1 sets `swld` at that edge. This is ignored while `swld` is already set.
- R5 (continued): At the next edge the current sample is loaded and `swld` returns to 0 by itself.
- R6: A `reg_wr` with `reg_wdata[0]`=0 has no effect on `swld` and causes no load.
- R7: Only the trigger named by `src_sel` in the current cycle matters. Events on other triggers are ignored and are not replayed when the selection changes.
- R8: A load attempted while the queue is full and not being read in the same cycle is dropped, and `ovf` is set. `ovf` stays set until a `reg_wr` with `reg_wdata[1]`=1 clears it. If a drop and a clear happen in the same cycle, the flag is set.
- R9: When a load and a read happen in the same cycle, both take effect and `level` is unchanged. This applies even when the queue is full.
- R10: `out_valid` equals not-empty. `out_data` is the oldest stored word, and words leave in load order. `out_ready` while empty has no effect.
- R11: After reset, `level` is 0, `empty` is 1, `full` is 0, `out_valid` is 0, `ovf` is 0 and `swld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_data | input | 16 | Current filtered sample |
| smp_rdy | input | 1 | New-sample strobe from the filter |
| tmr_evt | input | 3 | Timer event pulses, one bit per timer |
| src_sel | input | 3 | Load trigger select code |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 2 | Bit 0: software load, bit 1: overflow clear |
| out_valid | output | 1 | Queue holds a word |
| out_ready | input | 1 | Consumer takes the word at this edge |
| out_data | output | 16 | Oldest stored word |
| empty | output | 1 | Queue empty |
| full | output | 1 | Queue full |
| level | output | 4 | Number of stored words |
| ovf | output | 1 | Sticky dropped-load flag |
| swld | output | 1 | Software load bit, pending load |

## Verification
The two functions that can fall in the same cycle are a trigger-driven load and a stream read. The key case is when they coincide with a full queue, because the read must make room for the load instead of the load being dropped. The bench provokes this by filling the queue with `out_ready` low and then raising `out_ready` while the ready strobe stays high. A second set of runs drives random triggers, selects and ready.

A behavioural queue model predicts the level, the head word and the overflow flag on every clock, and the bench compares against it. A collision that is handled wrongly shows up either as a spurious `ovf` or as a level that drifts away from the model.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
  localparam int SMP_W = 16;
  localparam int N_TMR = 3;
  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SRC_TMR0   = 3'd0,
    SRC_TMR1   = 3'd1,
    SRC_TMR2   = 3'd2,
    SRC_RSV3   = 3'd3,
    SRC_RSV4   = 3'd4,
    SRC_RSV5   = 3'd5,
    SRC_STREAM = 3'd6,
    SRC_SOFT   = 3'd7
  } src_e;
endpackage

// File: rtl/tsf_trig_sel.sv
module tsf_trig_sel
  import tsf_pkg::*;
#(
  parameter int NT = N_TMR
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic [NT-1:0]    tmr_evt,
  input  logic             smp_rdy,
  input  logic             wr_en,
  input  logic             wr_load,
  output logic             load_req,
  output logic             swld_q
);
  logic [NT-1:0] tmr_hit;
  logic          soft_mode;
  logic          rsvd;

  // one match term per timer input
  for (genvar i = 0; i < NT; i++) begin : g_tmr
    assign tmr_hit[i] = tmr_evt[i] && (sel == SEL_W'(i));
  end

  assign soft_mode = (sel == SRC_SOFT);
  assign rsvd      = (sel == SRC_RSV3) || (sel == SRC_RSV4) || (sel == SRC_RSV5);

  // the software bit lives for exactly one cycle: set by a write, consumed next edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) swld_q <= 1'b0;
    else        swld_q <= !swld_q && wr_en && wr_load && soft_mode;
  end

  always_comb begin
    load_req = |tmr_hit;
    if (sel == SRC_STREAM) load_req = smp_rdy;
    if (soft_mode)         load_req = swld_q;
  end

  AST_RSVD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsvd |-> !load_req); // R3
  AST_SWLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    swld_q |=> !swld_q); // R5
  AST_ZERO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!swld_q && !(wr_en && wr_load)) |=> !swld_q); // R6
endmodule

// File: rtl/tsf_fifo.sv
module tsf_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] count,
  output logic          drop
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          pop_ok, push_ok;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign pop_ok  = pop && !empty;
  assign push_ok = push && (!full || pop_ok);
  assign drop    = push && !push_ok;
  assign rdata   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= nxt(wr_ptr);
      if (pop_ok)  rd_ptr <= nxt(rd_ptr);
      if (push_ok && !pop_ok)      count <= count + 1'b1;
      else if (pop_ok && !push_ok) count <= count - 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R1
  AST_PUSHPOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && pop_ok) |=> count == $past(count)); // R9
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> full && $stable(rd_ptr)); // R8
endmodule

// File: rtl/trig_sample_fifo.sv
module trig_sample_fifo
  import tsf_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SMP_W-1:0] smp_data,
  input  logic             smp_rdy,
  input  logic [N_TMR-1:0] tmr_evt,
  input  logic [SEL_W-1:0] src_sel,
  input  logic             reg_wr,
  input  logic [1:0]       reg_wdata,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [SMP_W-1:0] out_data,
  output logic             empty,
  output logic             full,
  output logic [CW-1:0]    level,
  output logic             ovf,
  output logic             swld
);
  logic load_req;
  logic drop;

  tsf_trig_sel #(.NT(N_TMR)) u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (src_sel),
    .tmr_evt  (tmr_evt),
    .smp_rdy  (smp_rdy),
    .wr_en    (reg_wr),
    .wr_load  (reg_wdata[0]),
    .load_req (load_req),
    .swld_q   (swld)
  );

  tsf_fifo #(.DW(SMP_W), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (load_req),
    .wdata (smp_data),
    .pop   (out_ready),
    .rdata (out_data),
    .empty (empty),
    .full  (full),
    .count (level),
    .drop  (drop)
  );

  assign out_valid = !empty;

  // sticky: a drop outranks a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       ovf <= 1'b0;
    else if (drop)                    ovf <= 1'b1;
    else if (reg_wr && reg_wdata[1])  ovf <= 1'b0;
  end

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !(reg_wr && reg_wdata[1])) |=> ovf); // R8
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !load_req) |=> empty); // R10
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full)); // R1
endmodule

// File: tb/trig_sample_fifo_bench.sv
module trig_sample_fifo_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] smp_data = '0;
  logic        smp_rdy = 1'b0;
  logic [2:0]  tmr_evt = '0;
  logic [2:0]  src_sel = '0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_wdata = '0;
  logic        out_valid, out_ready = 1'b0;
  logic [15:0] out_data;
  logic        empty, full, ovf, swld;
  logic [3:0]  level;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [15:0] m_q[$];
  bit          m_sw = 0;
  bit          m_ovf = 0;

  always #4 clk = ~clk; // 125 MHz

  trig_sample_fifo u_trig_sample_fifo (
    .clk(clk), .rst_n(rst_n), .smp_data(smp_data), .smp_rdy(smp_rdy),
    .tmr_evt(tmr_evt), .src_sel(src_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .empty(empty), .full(full), .level(level), .ovf(ovf), .swld(swld)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare(input string req);
    int n = m_q.size();
    chk(int'(level) == n, req, "level (R1)", int'(level), n);
    chk(empty == (n == 0), req, "empty (R1)", int'(empty), int'(n == 0));
    chk(full == (n == 8), req, "full (R1)", int'(full), int'(n == 8));
    chk(out_valid == (n != 0), req, "out_valid (R10)", int'(out_valid), int'(n != 0));
    if (n != 0) chk(out_data == m_q[0], req, "out_data (R10)", int'(out_data), int'(m_q[0]));
    chk(ovf == m_ovf, req, "ovf (R8)", int'(ovf), int'(m_ovf));
    chk(swld == m_sw, req, "swld (R5)", int'(swld), int'(m_sw));
  endtask

  // one clock: check outputs, drive inputs, advance the model
  task automatic step(input string req, input logic [2:0] sel, input logic [2:0] tmr,
                      input logic rdy, input logic wr, input logic [1:0] wd,
                      input logic ordy);
    bit trig, pop, push_ok, drop;
    logic [15:0] d;
    @(negedge clk);
    compare(req);
    d = 16'($urandom);
    smp_data = d; src_sel = sel; tmr_evt = tmr; smp_rdy = rdy;
    reg_wr = wr; reg_wdata = wd; out_ready = ordy;
    case (sel)
      3'd0, 3'd1, 3'd2: trig = tmr[sel];
      3'd6:             trig = rdy;
      3'd7:             trig = m_sw;
      default:          trig = 0;
    endcase
    pop = ordy && (m_q.size() != 0);
    push_ok = trig && (m_q.size() < 8 || pop);
    drop = trig && !push_ok;
    @(posedge clk);
    if (pop) void'(m_q.pop_front());
    if (push_ok) m_q.push_back(d);
    m_sw = !m_sw && wr && wd[0] && (sel == 3'd7);
    if (drop) m_ovf = 1;
    else if (wr && wd[1]) m_ovf = 0;
  endtask

  function automatic logic [2:0] rb3();
    return 3'($urandom);
  endfunction
  function automatic logic rb();
    return 1'($urandom);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R11");
    rst_n = 1'b1;
    // R2: timer selects, random pulses and reads
    for (int s = 0; s < 3; s++)
      for (int i = 0; i < 60; i++) step("R2", 3'(s), rb3(), rb(), 0, 2'b00, rb());
    // R3: reserved codes, every trigger and software writes active
    for (int s = 3; s < 6; s++)
      for (int i = 0; i < 40; i++) step("R3", 3'(s), 3'b111, 1, rb(), 2'b01, rb());
    // R4: stream strobe
    for (int i = 0; i < 80; i++) step("R4", 3'd6, rb3(), rb(), 0, 2'b00, rb());
    // R5: software loads, including back-to-back writes
    for (int i = 0; i < 80; i++) step("R5", 3'd7, 3'b111, 1, rb(), 2'b01, rb());
    // R6: zero writes
    for (int i = 0; i < 40; i++) step("R6", 3'd7, 3'b111, 1, 1, 2'b00, rb());
    // R7: selection changes every cycle
    for (int i = 0; i < 400; i++) step("R7", rb3(), rb3(), rb(), rb(), {1'b0, rb()}, rb());
    // drain
    for (int i = 0; i < 10; i++) step("R10", 3'd3, 3'b000, 0, 0, 2'b00, 1);
    // R10: ready while empty
    for (int i = 0; i < 5; i++) step("R10", 3'd3, 3'b000, 0, 0, 2'b00, 1);
    // R1/R8: fill past the top with no reader
    for (int i = 0; i < 12; i++) step("R8", 3'd6, 3'b000, 1, 0, 2'b00, 0);
    // R8: drop and clear in the same cycle, set wins
    step("R8", 3'd6, 3'b000, 1, 1, 2'b10, 0);
    step("R8", 3'd6, 3'b000, 0, 1, 2'b10, 0);
    step("R8", 3'd6, 3'b000, 0, 0, 2'b00, 0);
    // R9: full with simultaneous load and read
    for (int i = 0; i < 20; i++) step("R9", 3'd6, 3'b000, 1, 0, 2'b00, 1);
    for (int i = 0; i < 20; i++) step("R9", 3'd6, 3'b000, rb(), 0, 2'b00, rb());
    // R1: full drain to empty
    for (int i = 0; i < 12; i++) step("R1", 3'd4, 3'b000, 0, 1, 2'b10, 1);
    @(negedge clk);
    compare("R1");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule